// File: doc/BRIEF.md
# Retriggerable Fixed-Width Pulse Stretcher

The block turns a trigger level into an active-high output pulse whose length is a fixed number of clock cycles. There are two ways in. On the bypass path the output follows a rising trigger through gates only, with no clock latency and no jitter, so it also follows glitches. A synchronized edge detector then takes over and holds the output for the programmed width. On the filtered path the trigger passes through a two-flop synchronizer and a run-length glitch filter. A fixed alignment pipeline then starts the pulse a constant number of cycles after the first clock edge that sees the trigger. This path rejects glitches but carries one cycle of sampling jitter.

An active-low filter select chooses the path, and a generation enable gates all new pulses. A trigger that arrives during a pulse is dropped, and a new pulse needs the trigger to go low first. A pulse that has started always runs to its full width, even if the path select changes while it runs. The reset is synchronous and active high. In bypass mode the trigger must stay high until the synchronized edge has started the timer, which takes three clock edges.

Top module: `pulse_stretch`

## Requirements
- R1: In the cycle after a reset edge `pulse_out` is low, whatever level `trig_in` has.
- R2: With `filter_n` low, take e1 as the first rising clock edge that samples `trig_in` high. If `trig_in` is sampled high on at least FILT_LEN+1 consecutive edges from e1, `pulse_out` rises after edge e(FILT_LEN+6) and falls after edge e(FILT_LEN+6+WIDTH). The output stays high for exactly WIDTH cycles.
- R3: With `filter_n` low, a trigger sampled high on FILT_LEN or fewer consecutive edges produces no pulse.
- R4: With `filter_n` high, `pulse_out` goes high in the same clock period that `trig_in` rises, before any clock edge. It falls after edge e(WIDTH+3).
- R5: While `gen_en` is low, no pulse starts on either path, and the bypass path does not pass the trigger to the output.
- R6: A trigger edge that arrives while a pulse is active is ignored and leaves the width unchanged. A trigger that stays high past the end of a pulse starts no second pulse.
- R7: A change of `filter_n` while a pulse is active does not shorten or lengthen that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| filter_n | input | 1 | Path select: 0 = synchronized glitch-filtered path, 1 = zero-latency bypass path |
| gen_en | input | 1 | Generation enable; new pulses start only while high |
| trig_in | input | 1 | Trigger level; may be asynchronous |
| pulse_out | output | 1 | Stretched pulse, active high |

## Verification
Two functions can meet in one cycle: a fresh trigger edge can reach the edge detector while the width timer is still counting down, and a path change can land while a pulse is running. The bench provokes the first in two ways. It raises the trigger again in the middle of a bypass pulse, and it holds the trigger high past the end of a pulse. It judges the result by the fall edge, which must stay at its nominal cycle, and by the count of rising edges, which must be one. It provokes the second by flipping `filter_n` in the middle of a pulse in each direction, and checks that the fall cycle is the one the original path predicts.

// File: rtl/stretch_pkg.sv
`timescale 1ns/1ps
package stretch_pkg;

    // Allowed range of the pulse width, in clock cycles
    localparam int unsigned WIDTH_MIN = 20;
    localparam int unsigned WIDTH_MAX = 40;

    // Level of the active-low filter select, seen as a path choice
    typedef enum logic {
        PATH_FILT   = 1'b0,
        PATH_BYPASS = 1'b1
    } path_e;

    // Bits needed to hold the values 0 .. v
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/stretch_sync.sv
`timescale 1ns/1ps
module stretch_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/stretch_glitch.sv
`timescale 1ns/1ps
module stretch_glitch
    import stretch_pkg::*;
#(
    parameter int unsigned FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic launch_ok,
    output logic fire
);
    localparam int unsigned RW = bits_for(FILT_LEN);
    localparam logic [RW-1:0] RUN_TOP = RW'(FILT_LEN);

    logic [RW-1:0] run_q;
    logic          filt_q, filt_d_q;
    logic          launch_q, align_q;

    // Length of the current run of high samples, saturating at FILT_LEN
    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (!level)         run_q <= '0;
        else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end

    // Accept once the level has been high on more than FILT_LEN samples
    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q   <= 1'b0;
            filt_d_q <= 1'b0;
        end else begin
            filt_q   <= level && (run_q == RUN_TOP);
            filt_d_q <= filt_q;
        end
    end

    // Fixed alignment pipeline to the start of the timer
    always_ff @(posedge clk) begin
        if (rst) begin
            launch_q <= 1'b0;
            align_q  <= 1'b0;
        end else begin
            launch_q <= filt_q & ~filt_d_q & launch_ok;
            align_q  <= launch_q;
        end
    end

    assign fire = align_q;

    // R3
    filt_run_chk: assert property (@(posedge clk) disable iff (rst)
        filt_q |-> $past(level))
        else $error("filtered level set without a high sample");

endmodule

// File: rtl/stretch_timer.sv
`timescale 1ns/1ps
module stretch_timer
    import stretch_pkg::*;
#(
    parameter int unsigned WIDTH = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic started
);
    localparam int unsigned CW = bits_for(WIDTH);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] left;
    } timer_t;

    timer_t st_q, st_d;

    assign started = start & ~st_q.active;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.left == '0) st_d.active = 1'b0;
            else                 st_d.left   = st_q.left - 1'b1;
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.left   = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = st_q.active;

    // Independent count of high cycles, used only by the checks below
    logic [CW:0] len_q;
    always_ff @(posedge clk) begin
        if (rst)               len_q <= '0;
        else if (st_q.active)  len_q <= len_q + 1'b1;
        else                   len_q <= '0;
    end

    // R2
    width_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.active) |-> ($past(len_q) == (CW + 1)'(WIDTH - 1)))
        else $error("pulse width differs from WIDTH");

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.active |-> (len_q < (CW + 1)'(WIDTH)))
        else $error("pulse ran past WIDTH cycles");

    // R7
    no_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.left != '0) |=> st_q.active)
        else $error("pulse cut short");

endmodule

// File: rtl/pulse_stretch.sv
`timescale 1ns/1ps
module pulse_stretch
    import stretch_pkg::*;
#(
    parameter int unsigned WIDTH    = 24,
    parameter int unsigned FILT_LEN = 2,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic filter_n,
    input  logic gen_en,
    input  logic trig_in,
    output logic pulse_out
);
    localparam int unsigned W_USED = (WIDTH < WIDTH_MIN) ? WIDTH_MIN :
                                     (WIDTH > WIDTH_MAX) ? WIDTH_MAX : WIDTH;

    path_e path;
    logic  lvl, rise;
    logic  fire;
    logic  active, started;
    logic  start_byp, start_filt;
    logic  armed_q;

    assign path = path_e'(filter_n);

    stretch_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (trig_in),
        .level (lvl),
        .rise  (rise)
    );

    stretch_glitch #(.FILT_LEN(FILT_LEN)) u_glitch (
        .clk       (clk),
        .rst       (rst),
        .level     (lvl),
        .launch_ok (path == PATH_FILT && gen_en),
        .fire      (fire)
    );

    assign start_byp  = rise & (path == PATH_BYPASS) & gen_en;
    assign start_filt = fire & gen_en;

    stretch_timer #(.WIDTH(W_USED)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start_byp | start_filt),
        .active  (active),
        .started (started)
    );

    // Bypass gate is armed only after the synchronized trigger was seen low
    // while idle; it closes when a pulse starts.
    always_ff @(posedge clk) begin
        if (rst)                  armed_q <= 1'b0;
        else if (started)         armed_q <= 1'b0;
        else if (!lvl && !active) armed_q <= 1'b1;
    end

    assign pulse_out = active |
                       ((path == PATH_BYPASS) & gen_en & trig_in & armed_q);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !pulse_out)
        else $error("output high after reset");

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |-> !started)
        else $error("pulse started while disabled");

endmodule

// File: tb/sim_pulse_stretch.sv
`timescale 1ns/1ps
module sim_pulse_stretch;
    localparam int W = 24;
    localparam int N = 2;
    localparam int F_RISE = N + 6;
    localparam int F_FALL = N + 6 + W;
    localparam int B_FALL = W + 3;

    logic clk = 1'b0;
    logic rst, filter_n, gen_en, trig_in;
    logic pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_stretch #(.WIDTH(W), .FILT_LEN(N)) u0 (
        .clk(clk), .rst(rst), .filter_n(filter_n), .gen_en(gen_en),
        .trig_in(trig_in), .pulse_out(pulse_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        trig_in = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Raise trig at a falling edge; e1 is the next rising edge.
    task automatic run(input int hold, input int span,
                       input int re_at, input int re_len,
                       input int flip_at, input logic flip_val,
                       output int rise_at, output int fall_at,
                       output int rises, output int comb_hi);
        logic prev;
        rise_at = -1; fall_at = -1; rises = 0;
        @(negedge clk);
        trig_in = 1'b1;
        #1;
        comb_hi = int'(pulse_out);
        prev = pulse_out;
        if (pulse_out) begin rise_at = 0; rises = 1; end
        for (int e = 1; e <= span; e++) begin
            @(posedge clk);
            #1;
            if (pulse_out && !prev) begin
                rises++;
                if (rise_at < 0) rise_at = e;
            end
            if (!pulse_out && prev && fall_at < 0) fall_at = e;
            prev = pulse_out;
            if (e == hold) trig_in = 1'b0;
            if (e == re_at) trig_in = 1'b1;
            if (e == re_at + re_len) trig_in = 1'b0;
            if (e == flip_at) filter_n = flip_val;
        end
        trig_in = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; filter_n = 1'b1; gen_en = 1'b1; trig_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 output during reset", int'(pulse_out), 0);
        trig_in = 1'b0;
        rst = 1'b0;
        idle(10);
        check("R1 output after reset", int'(pulse_out), 0);
    endtask

    task automatic t_filtered();
        int r, f, n, c;
        filter_n = 1'b0;
        run(10, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R2 filtered rise edge", r, F_RISE);
        check("R2 filtered fall edge", f, F_FALL);
        check("R2 filtered no early output", c, 0);
        idle(20);
        run(N + 1, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R2 shortest accepted rise", r, F_RISE);
        check("R2 shortest accepted fall", f, F_FALL);
        idle(20);
        run(N, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R3 short trigger rejected", n, 0);
        idle(20);
        run(1, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R3 one-cycle glitch rejected", n, 0);
        idle(20);
    endtask

    task automatic t_bypass();
        int r, f, n, c;
        filter_n = 1'b1;
        run(5, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R4 output before any edge", c, 1);
        check("R4 bypass fall edge", f, B_FALL);
        check("R4 single pulse", n, 1);
        idle(20);
    endtask

    task automatic t_enable();
        int r, f, n, c;
        gen_en = 1'b0;
        filter_n = 1'b1;
        run(5, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R5 bypass gated", c, 0);
        check("R5 bypass no pulse", n, 0);
        idle(20);
        filter_n = 1'b0;
        run(10, 60, -10, 0, -1, 1'b0, r, f, n, c);
        check("R5 filtered no pulse", n, 0);
        gen_en = 1'b1;
        idle(40);
        check("R5 nothing pending after enable", int'(pulse_out), 0);
        idle(10);
    endtask

    task automatic t_retrigger();
        int r, f, n, c;
        filter_n = 1'b1;
        run(5, 60, 12, 5, -1, 1'b0, r, f, n, c);
        check("R6 retrigger width kept", f, B_FALL);
        check("R6 retrigger ignored", n, 1);
        idle(20);
        run(45, 70, -10, 0, -1, 1'b0, r, f, n, c);
        check("R6 held trigger fall", f, B_FALL);
        check("R6 held trigger single pulse", n, 1);
        idle(20);
        filter_n = 1'b0;
        run(45, 70, -10, 0, -1, 1'b0, r, f, n, c);
        check("R6 held filtered single pulse", n, 1);
        idle(20);
    endtask

    task automatic t_mode_flip();
        int r, f, n, c;
        filter_n = 1'b0;
        run(10, 60, -10, 0, 15, 1'b1, r, f, n, c);
        check("R7 filtered to bypass fall", f, F_FALL);
        check("R7 filtered to bypass count", n, 1);
        idle(20);
        filter_n = 1'b1;
        run(5, 60, -10, 0, 10, 1'b0, r, f, n, c);
        check("R7 bypass to filtered fall", f, B_FALL);
        check("R7 bypass to filtered count", n, 1);
        idle(20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_filtered();
        t_bypass();
        t_enable();
        t_retrigger();
        t_mode_flip();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule